// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, and folds the outcome into a copy of a floating-point status word. The outcome is a 2-bit condition code. A field select picks one of four condition fields in the word, and the new code goes into that field. The previous contents of that field are discarded first. Any operand that is not a number makes the pair unordered. For an unordered pair the block reads an invalid-operation trap-enable bit from the incoming status word. It then either requests a floating-point exception trap or sets a sticky accrued-invalid flag.

The surrounding pipeline owns the status register. It presents the current value on `stat_i` together with the operands and pulses `start_i` for one cycle. One clock later the block pulses `done_o` and presents the updated word on `stat_o`. In that same cycle it pulses `trap_o` if a trap is requested. `stat_o` then holds its value until the next start.

The controller has two states. ST_IDLE waits for work. The transition ST_IDLE to ST_DONE is taken on a start. In ST_DONE the result is presented. From ST_DONE, a further start gives the transition ST_DONE to ST_DONE, which serves back-to-back compares. With no start, ST_DONE returns to ST_IDLE.

Top module: `fcc_compare_unit`

## Requirements
- R1: The code written is 0 when the operands are equal, 1 when operand A is less than B, 2 when A is greater than B, and 3 when the pair is unordered.
- R2: Field select 0 places the code in `stat_o[11:10]`. Selects 1, 2 and 3 place it in `[33:32]`, `[35:34]` and `[37:36]`, so fields 1 to 3 sit 22, 24 and 26 bits above field 0. Bit 0 of the code is the lower bit of the field.
- R3: Both bits of the selected field are cleared before the new code is inserted, so a stale 3 can be replaced by 0.
- R4: For an unordered pair with `stat_i[27]` (trap enable) set, the field receives 3 and `trap_o` pulses with `done_o`. `stat_o[9]` (accrued invalid) is then copied unchanged.
- R5: For an unordered pair with `stat_i[27]` clear, the field receives 3 and `stat_o[9]` is set. `trap_o` stays low.
- R6: With `dbl_i`=1 the full 64-bit operands are compared as double precision. With `dbl_i`=0 only bits [31:0] are used as single precision, and bits [63:32] have no effect.
- R7: Ordered operands compare by sign and magnitude. +0 and -0 are equal, every negative value is less than every positive value, and infinities order as the largest magnitudes.
- R8: An operand is unordered exactly when its exponent field is all ones and its fraction is non-zero. An all-ones exponent with a zero fraction (infinity) is ordered.
- R9: `done_o` is high exactly in the cycle after each cycle in which `start_i` is high.
- R10: Every `stat_o` bit other than the selected field and bit 9 equals the `stat_i` value sampled at start. `stat_o` is stable in every cycle without `done_o`.
- R11: During reset `stat_o` is zero and `done_o` and `trap_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a compare this cycle |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| fld_sel_i | input | 2 | Condition field to write |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| stat_i | input | 64 | Current status word |
| stat_o | output | 64 | Updated status word |
| trap_o | output | 1 | Floating-point exception trap request pulse |
| done_o | output | 1 | Result valid pulse |

## Verification
The field rewrite and the trap request fall in the same cycle whenever an unordered pair meets a set trap-enable bit. In that cycle the code 3 must still land in the selected field, and the accrued flag must pass through untouched. The sweep provokes this for every NaN-bearing operand pair, in all four fields and in both precisions. The accrued bit is preset in half of these cases, so the bench can tell a pass-through from a spurious set. A back-to-back pair of starts also makes a new result and the previous done pulse overlap. Each cycle is judged against the expected word.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } fcc_state_e;

    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned CC_W       = 2;

    // Field 0 at base, field k>0 at base + first_step + CC_W*(k-1).
    function automatic int unsigned fld_lsb(int unsigned base,
                                            int unsigned first_step,
                                            int unsigned sel);
        if (sel == 0) return base;
        return base + first_step + CC_W * (sel - 1);
    endfunction

endpackage

// File: rtl/fcc_classify.sv
module fcc_classify #(
    parameter int unsigned SP_EXP  = 8,
    parameter int unsigned SP_FRAC = 23,
    parameter int unsigned DP_EXP  = 11,
    parameter int unsigned DP_FRAC = 52,
    localparam int unsigned DW     = 1 + DP_EXP + DP_FRAC,
    localparam int unsigned SW_SP  = 1 + SP_EXP + SP_FRAC,
    localparam int unsigned MW     = DW - 1
) (
    input  logic [DW-1:0] raw_i,
    input  logic          dbl_i,
    output logic          nan_o,
    output logic          sign_o,
    output logic          zero_o,
    output logic [MW-1:0] mag_o
);
    logic sp_exp_ones, dp_exp_ones, sp_frac_nz, dp_frac_nz;

    assign sp_exp_ones = &raw_i[SW_SP-2:SP_FRAC];
    assign sp_frac_nz  = |raw_i[SP_FRAC-1:0];
    assign dp_exp_ones = &raw_i[DW-2:DP_FRAC];
    assign dp_frac_nz  = |raw_i[DP_FRAC-1:0];

    always_comb begin
        if (dbl_i) begin
            nan_o  = dp_exp_ones & dp_frac_nz;
            sign_o = raw_i[DW-1];
            mag_o  = raw_i[MW-1:0];
        end else begin
            nan_o  = sp_exp_ones & sp_frac_nz;
            sign_o = raw_i[SW_SP-1];
            mag_o  = MW'(raw_i[SW_SP-2:0]);
        end
        zero_o = (mag_o == '0);
    end
endmodule

// File: rtl/fcc_order.sv
module fcc_order
    import fcc_pkg::*;
#(
    parameter int unsigned MW = 63
) (
    input  logic          a_nan_i,
    input  logic          a_sign_i,
    input  logic          a_zero_i,
    input  logic [MW-1:0] a_mag_i,
    input  logic          b_nan_i,
    input  logic          b_sign_i,
    input  logic          b_zero_i,
    input  logic [MW-1:0] b_mag_i,
    output cc_code_e      code_o
);
    logic mag_lt, mag_eq;

    assign mag_lt = (a_mag_i < b_mag_i);
    assign mag_eq = (a_mag_i == b_mag_i);

    always_comb begin
        if (a_nan_i || b_nan_i) begin
            code_o = CC_UN;
        end else if (a_zero_i && b_zero_i) begin
            code_o = CC_EQ;
        end else if (a_sign_i != b_sign_i) begin
            code_o = a_sign_i ? CC_LT : CC_GT;
        end else if (mag_eq) begin
            code_o = CC_EQ;
        end else if (a_sign_i) begin
            code_o = mag_lt ? CC_GT : CC_LT;
        end else begin
            code_o = mag_lt ? CC_LT : CC_GT;
        end
    end
endmodule

// File: rtl/fcc_merge.sv
module fcc_merge
    import fcc_pkg::*;
#(
    parameter int unsigned SW          = 64,
    parameter int unsigned CC_BASE     = 10,
    parameter int unsigned FIRST_STEP  = 22,
    parameter int unsigned TRAP_EN_BIT = 27,
    parameter int unsigned ACCR_BIT    = 9
) (
    input  logic [SW-1:0] stat_i,
    input  logic [1:0]    sel_i,
    input  cc_code_e      code_i,
    output logic [SW-1:0] stat_o,
    output logic          trap_o
);
    logic [SW-1:0] fmask [NUM_FIELDS];
    logic [SW-1:0] fval  [NUM_FIELDS];
    logic          unordered;

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        localparam int unsigned LSB = fld_lsb(CC_BASE, FIRST_STEP, k);
        assign fmask[k] = SW'(2'b11) << LSB;
        assign fval[k]  = SW'(code_i) << LSB;
    end

    assign unordered = (code_i == CC_UN);

    always_comb begin
        stat_o = (stat_i & ~fmask[sel_i]) | fval[sel_i];
        trap_o = 1'b0;
        if (unordered) begin
            if (stat_i[TRAP_EN_BIT]) trap_o = 1'b1;
            else                     stat_o[ACCR_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
    import fcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic done_o
);
    fcc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_DONE;
            ST_DONE: state_d = start_i ? ST_DONE : ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = start_i;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: done_o = 1'b0;
            ST_DONE: done_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/fcc_compare_unit.sv
module fcc_compare_unit
    import fcc_pkg::*;
#(
    parameter int unsigned SP_EXP      = 8,
    parameter int unsigned SP_FRAC     = 23,
    parameter int unsigned DP_EXP      = 11,
    parameter int unsigned DP_FRAC     = 52,
    parameter int unsigned SW          = 64,
    parameter int unsigned CC_BASE     = 10,
    parameter int unsigned FIRST_STEP  = 22,
    parameter int unsigned TRAP_EN_BIT = 27,
    parameter int unsigned ACCR_BIT    = 9,
    localparam int unsigned DW         = 1 + DP_EXP + DP_FRAC,
    localparam int unsigned MW         = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dbl_i,
    input  logic [1:0]    fld_sel_i,
    input  logic [DW-1:0] op_a_i,
    input  logic [DW-1:0] op_b_i,
    input  logic [SW-1:0] stat_i,
    output logic [SW-1:0] stat_o,
    output logic          trap_o,
    output logic          done_o
);
    logic [DW-1:0] ops   [2];
    logic          nan_w [2];
    logic          sgn_w [2];
    logic          zro_w [2];
    logic [MW-1:0] mag_w [2];

    assign ops[0] = op_a_i;
    assign ops[1] = op_b_i;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcc_classify #(
            .SP_EXP (SP_EXP),
            .SP_FRAC(SP_FRAC),
            .DP_EXP (DP_EXP),
            .DP_FRAC(DP_FRAC)
        ) u_cls (
            .raw_i (ops[g]),
            .dbl_i (dbl_i),
            .nan_o (nan_w[g]),
            .sign_o(sgn_w[g]),
            .zero_o(zro_w[g]),
            .mag_o (mag_w[g])
        );
    end

    cc_code_e code_w;

    fcc_order #(.MW(MW)) u_ord (
        .a_nan_i (nan_w[0]), .a_sign_i(sgn_w[0]), .a_zero_i(zro_w[0]), .a_mag_i(mag_w[0]),
        .b_nan_i (nan_w[1]), .b_sign_i(sgn_w[1]), .b_zero_i(zro_w[1]), .b_mag_i(mag_w[1]),
        .code_o  (code_w)
    );

    logic [SW-1:0] stat_new;
    logic          trap_new;

    fcc_merge #(
        .SW         (SW),
        .CC_BASE    (CC_BASE),
        .FIRST_STEP (FIRST_STEP),
        .TRAP_EN_BIT(TRAP_EN_BIT),
        .ACCR_BIT   (ACCR_BIT)
    ) u_mrg (
        .stat_i(stat_i),
        .sel_i (fld_sel_i),
        .code_i(code_w),
        .stat_o(stat_new),
        .trap_o(trap_new)
    );

    logic load;

    fcc_ctrl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .load_o (load),
        .done_o (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
            trap_o <= 1'b0;
        end else begin
            trap_o <= load & trap_new;
            if (load) stat_o <= stat_new;
        end
    end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int unsigned SW          = 64,
    parameter int unsigned TRAP_EN_BIT = 27,
    parameter int unsigned ACCR_BIT    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [SW-1:0] stat_i,
    input logic [SW-1:0] stat_o,
    input logic          trap_o,
    input logic          done_o
);
    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R9
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i)); // R9
    AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> done_o); // R4
    AST_TRAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(stat_i[TRAP_EN_BIT])); // R4
    AST_TRAP_KEEPS_ACCR: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (stat_o[ACCR_BIT] == $past(stat_i[ACCR_BIT]))); // R4
    AST_ACCR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(stat_i[ACCR_BIT])) |-> stat_o[ACCR_BIT]); // R5
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(stat_o)); // R10
endmodule

bind fcc_compare_unit fcc_checker #(
    .SW         (SW),
    .TRAP_EN_BIT(TRAP_EN_BIT),
    .ACCR_BIT   (ACCR_BIT)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .stat_i (stat_i),
    .stat_o (stat_o),
    .trap_o (trap_o),
    .done_o (done_o)
);

// File: tb/fcc_compare_unit_tb.sv
`timescale 1ns/1ps
module fcc_compare_unit_tb;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [1:0]  fld_sel_i = '0;
    logic [63:0] op_a_i = '0, op_b_i = '0, stat_i = '0;
    logic [63:0] stat_o;
    logic        trap_o, done_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fcc_compare_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .fld_sel_i(fld_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .stat_i(stat_i), .stat_o(stat_o), .trap_o(trap_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sp_val(input int i);
        case (i)
            0: return 64'h0000_0000;  1: return 64'h8000_0000;
            2: return 64'h3f80_0000;  3: return 64'hbf80_0000;
            4: return 64'h4000_0000;  5: return 64'hc000_0000;
            6: return 64'h7f80_0000;  7: return 64'hff80_0000;
            8: return 64'h7fc0_0000;  9: return 64'h7f80_0001;
            10: return 64'hffc0_0000; 11: return 64'h0000_0001;
            12: return 64'h7f7f_ffff; default: return 64'h8000_0001;
        endcase
    endfunction

    function automatic logic [63:0] dp_val(input int i);
        case (i)
            0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
            2: return 64'h3ff0_0000_0000_0000;  3: return 64'hbff0_0000_0000_0000;
            4: return 64'h4000_0000_0000_0000;  5: return 64'hc000_0000_0000_0000;
            6: return 64'h7ff0_0000_0000_0000;  7: return 64'hfff0_0000_0000_0000;
            8: return 64'h7ff8_0000_0000_0000;  9: return 64'h7ff0_0000_0000_0001;
            10: return 64'hfff8_0000_0000_0000; 11: return 64'h0000_0000_0000_0001;
            12: return 64'h7fef_ffff_ffff_ffff; default: return 64'h8000_0000_0000_0001;
        endcase
    endfunction

    // R8: unordered when exponent all ones and fraction non-zero
    function automatic bit tb_nan(input logic [63:0] v, input bit dbl);
        if (dbl) return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
        return (v[30:23] == 8'hff) && (v[22:0] != 0);
    endfunction

    // R7: signed ordering key, -0 maps to 0
    function automatic longint tb_key(input logic [63:0] v, input bit dbl);
        longint m;
        bit s;
        m = dbl ? longint'(v[62:0]) : longint'(v[30:0]);
        s = dbl ? v[63] : v[31];
        return s ? -m : m;
    endfunction

    function automatic int tb_lsb(input int sel);
        return (sel == 0) ? 10 : 30 + 2 * sel;  // R2
    endfunction

    function automatic logic [1:0] tb_code(input logic [63:0] a, input logic [63:0] b, input bit dbl);
        longint ka, kb;
        if (tb_nan(a, dbl) || tb_nan(b, dbl)) return 2'd3;
        ka = tb_key(a, dbl);
        kb = tb_key(b, dbl);
        if (ka == kb) return 2'd0;
        return (ka < kb) ? 2'd1 : 2'd2;  // R1
    endfunction

    task automatic run_one(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                           input int sel, input logic [63:0] sin);
        logic [1:0]  code;
        logic [63:0] exp_s;
        bit          exp_t, un;
        code  = tb_code(a, b, dbl);
        un    = (code == 2'd3);
        exp_s = sin & ~(64'h3 << tb_lsb(sel));     // R3
        exp_s = exp_s | (64'(code) << tb_lsb(sel));
        exp_t = un && sin[27];
        if (un && !sin[27]) exp_s[9] = 1'b1;        // R5
        op_a_i = dbl ? a : {32'hdead_beef, a[31:0]};  // R6 upper half ignored
        op_b_i = dbl ? b : {32'hc0ff_ee11, b[31:0]};
        dbl_i = dbl; fld_sel_i = 2'(sel); stat_i = sin; start_i = 1'b1;
        @(negedge clk);
        check(done_o == 1'b1, "R9 done", 64'(done_o), 64'd1);
        check(stat_o == exp_s, dbl ? "R1/R2/R10 dbl (R6)" : "R1/R2/R10 sgl (R6)", stat_o, exp_s);
        check(trap_o == exp_t, un ? "R4/R5 trap" : "R4 no trap", 64'(trap_o), 64'(exp_t));
        start_i = 1'b0;
        stat_i = ~sin;
        @(negedge clk);
        check(done_o == 1'b0 && trap_o == 1'b0, "R9 single pulse", 64'({done_o, trap_o}), 64'd0);
        check(stat_o == exp_s, "R10 hold", stat_o, exp_s);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(stat_o == 64'd0 && !done_o && !trap_o, "R11 reset", stat_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0, "R9 idle after reset", 64'(done_o), 64'd0);

        for (int d = 0; d < 2; d++)
            for (int ia = 0; ia < NV; ia++)
                for (int ib = 0; ib < NV; ib++)
                    for (int fs = 0; fs < 4; fs++)
                        for (int te = 0; te < 2; te++) begin
                            logic [63:0] pat;
                            pat = 64'h9e37_79b9_7f4a_7c15 ^ (64'(ia) << 40)
                                ^ (64'(ib) << 3) ^ (64'(fs) << 56);
                            pat[27] = te[0];
                            pat[9]  = ia[0] ^ ib[0];
                            run_one(d[0] ? dp_val(ia) : sp_val(ia),
                                    d[0] ? dp_val(ib) : sp_val(ib), d[0], fs, pat);
                        end

        // R3: stale 3 in every field replaced by equal code 0
        for (int fs = 0; fs < 4; fs++)
            run_one(64'h0, 64'h8000_0000, 1'b0, fs, 64'hffff_ffff_f7ff_fdff);

        // R9: back-to-back starts
        op_a_i = 64'h3f80_0000; op_b_i = 64'h4000_0000; dbl_i = 1'b0;
        fld_sel_i = 2'd1; stat_i = 64'h0; start_i = 1'b1;
        @(negedge clk);
        check(done_o && stat_o == (64'd1 << 32), "R9 b2b first", stat_o, 64'd1 << 32);
        fld_sel_i = 2'd3; stat_i = 64'h0; op_a_i = 64'h4000_0000; op_b_i = 64'h3f80_0000;
        @(negedge clk);
        check(done_o && stat_o == (64'd2 << 36), "R9 b2b second", stat_o, 64'd2 << 36);
        start_i = 1'b0;
        @(negedge clk);
        check(!done_o, "R9 b2b end", 64'(done_o), 64'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule